// File: doc/BRIEF.md
# Dependency Token Synchronizer for a Load / Compute / Store Pipeline

This block lets three accelerator pipeline stages (load, compute, store) run ahead of each other safely, so that memory transfers overlap with arithmetic. The stages exchange permission tokens through four one-way token queues: load to compute, compute to load, compute to store, and store to compute. Every stage presents one instruction at a time. The instruction is a valid bit plus flags that say which queues it must take a token from and which queues it gives a token to. The block answers with a per-stage ready (issue enable). An instruction issues only in a cycle where every token it needs is present. Its pops and pushes take effect at that clock edge.

Stage identifiers are 1 for load, 2 for compute and 3 for store. Two virtual threads share the on-chip buffers in halves. To support this, the store-to-compute queue comes out of reset already holding one credit per thread, so compute can start both threads before any store has happened. For the thread that compute is working on, the block also supplies the buffer base offsets of that thread's half. When the program is over, an end request arms a completion detector. That detector raises a one-cycle global sync once compute has drained every outstanding credit and the pipeline is idle.

Top module: `vt_token_sync`

## Requirements
- R1: Out of reset, every queue is empty except store-to-compute, which holds NUM_VT (2) tokens. All readies, ovf_err and sync_done are low.
- R2: A load instruction with ld_pop_c2l set issues only if compute-to-load still has a token after any same-cycle compute claim. On issue it removes one token there and, with ld_push_l2c, adds one to load-to-compute.
- R3: A compute instruction issues only if each queue it pops (load-to-compute, compute-to-load, store-to-compute) holds a token. Compute takes precedence over load for the last compute-to-load token.
- R4: A store instruction with st_pop_c2s issues only if compute-to-store holds a token. On issue, st_push_s2c adds one token to store-to-compute.
- R5: A ready is never high without its valid. An instruction whose tokens are missing stays pending with ready low and issues in the first cycle its tokens are present.
- R6: A queue never holds more than DEPTH tokens. A push and a pop on the same queue in the same cycle leave its count unchanged, even when the queue is full.
- R7: A push into a full queue with no pop in that cycle is dropped. The matching ovf_err bit is high for the one following cycle. The bits are: 0 load-to-compute, 1 compute-to-load, 2 compute-to-store, 3 store-to-compute.
- R8: The buffer bases are combinational in cmp_thread: acc_base = thread·784, inp_base = thread·144, wgt_base = thread·72.
- R9: After end_req, sync_done pulses for one cycle. The pulse follows the first edge at which all queues are empty and no stage is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load instruction present |
| ld_pop_c2l | input | 1 | Load needs a compute-to-load token |
| ld_push_l2c | input | 1 | Load gives a load-to-compute token |
| ld_ready | output | 1 | Load instruction issues this cycle |
| cmp_valid | input | 1 | Compute instruction present |
| cmp_pop_l2c | input | 1 | Compute needs a load-to-compute token |
| cmp_pop_c2l | input | 1 | Compute drains a compute-to-load token |
| cmp_pop_s2c | input | 1 | Compute needs a store-to-compute token |
| cmp_push_c2l | input | 1 | Compute gives a compute-to-load token |
| cmp_push_c2s | input | 1 | Compute gives a compute-to-store token |
| cmp_thread | input | TW | Virtual thread of the compute instruction |
| cmp_ready | output | 1 | Compute instruction issues this cycle |
| acc_base | output | ACC_W | Accumulator base for cmp_thread |
| inp_base | output | INP_W | Input buffer base for cmp_thread |
| wgt_base | output | WGT_W | Weight buffer base for cmp_thread |
| st_valid | input | 1 | Store instruction present |
| st_pop_c2s | input | 1 | Store needs a compute-to-store token |
| st_push_s2c | input | 1 | Store gives a store-to-compute token |
| st_ready | output | 1 | Store instruction issues this cycle |
| end_req | input | 1 | Program end marker |
| ovf_err | output | 4 | Per-queue dropped-push flag |
| sync_done | output | 1 | Global completion pulse |

## Verification
Some properties hold on every cycle and are checked that way. No queue gives a token it does not have, and no count passes DEPTH. A balanced push and pop leaves a count still. A push into a full queue raises its error bit and leaves the count at DEPTH. No ready appears without its valid, and sync only fires with every queue empty.

Other behaviour depends on history, so only the bench's scenarios can show it:
- the two seeded credits after reset;
- compute winning the last shared token over load;
- a held instruction issuing once its token arrives;
- a full two-thread load/compute/store replay ending in exactly one sync pulse.

// File: rtl/vt_sync_pkg.sv
package vt_sync_pkg;
   typedef enum logic [1:0] {
      STG_NONE = 2'd0,
      STG_LD   = 2'd1,
      STG_CMP  = 2'd2,
      STG_ST   = 2'd3
   } stage_e;

   localparam int NSTG = 3;
   localparam int NQ   = 4;
   localparam int PW   = $clog2(NSTG + 1);

   // queue slots; ovf_err bit order follows these
   localparam int Q_L2C = 0;
   localparam int Q_C2L = 1;
   localparam int Q_C2S = 2;
   localparam int Q_S2C = 3;

   // stage slot = stage id - 1
   localparam int S_LD  = int'(STG_LD) - 1;
   localparam int S_CMP = int'(STG_CMP) - 1;
   localparam int S_ST  = int'(STG_ST) - 1;

   // order in which stages claim tokens of a shared queue
   localparam stage_e PRIO [NSTG] = '{STG_CMP, STG_LD, STG_ST};
endpackage

// File: rtl/vt_tok_cnt.sv
module vt_tok_cnt
   import vt_sync_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int INIT  = 0,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [PW-1:0] pop_n,
   output logic [CW-1:0] cnt,
   output logic          ovf
);
   logic          drop;
   logic [CW-1:0] nxt;

   always_comb begin
      drop = push && (pop_n == '0) && (cnt == CW'(DEPTH));
      nxt  = cnt + CW'(push) - CW'(pop_n);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= CW'(INIT);
         ovf <= 1'b0;
      end else begin
         ovf <= drop;
         if (!drop) cnt <= nxt;
      end
   end
endmodule

// File: rtl/vt_issue_arb.sv
module vt_issue_arb
   import vt_sync_pkg::*;
#(
   parameter int CW = 3
) (
   input  logic [NSTG-1:0]          valid,
   input  logic [NSTG-1:0][NQ-1:0]  pop_mask,
   input  logic [NSTG-1:0][NQ-1:0]  push_mask,
   input  logic [NQ-1:0][CW-1:0]    cnt,
   output logic [NSTG-1:0]          issue,
   output logic [NQ-1:0]            push,
   output logic [NQ-1:0][PW-1:0]    pop_n
);
   always_comb begin
      int   s;
      logic ok;
      issue = '0;
      pop_n = '0;
      push  = '0;
      for (int p = 0; p < NSTG; p++) begin
         s  = int'(PRIO[p]) - 1;
         ok = valid[s];
         for (int q = 0; q < NQ; q++)
            if (pop_mask[s][q] && (int'(cnt[q]) <= int'(pop_n[q]))) ok = 1'b0;
         issue[s] = ok;
         for (int q = 0; q < NQ; q++)
            if (ok && pop_mask[s][q]) pop_n[q] = pop_n[q] + PW'(1);
      end
      for (int st = 0; st < NSTG; st++)
         for (int q = 0; q < NQ; q++)
            push[q] = push[q] | (issue[st] & push_mask[st][q]);
   end
endmodule

// File: rtl/vt_base.sv
module vt_base #(
   parameter int NUM_VT     = 2,
   parameter int ACC_STRIDE = 784,
   parameter int INP_STRIDE = 144,
   parameter int WGT_STRIDE = 72,
   parameter int ACC_W      = 11,
   parameter int INP_W      = 9,
   parameter int WGT_W      = 8,
   localparam int TW        = (NUM_VT > 1) ? $clog2(NUM_VT) : 1
) (
   input  logic [TW-1:0]    thread,
   output logic [ACC_W-1:0] acc_base,
   output logic [INP_W-1:0] inp_base,
   output logic [WGT_W-1:0] wgt_base
);
   always_comb begin
      acc_base = ACC_W'(int'(thread) * ACC_STRIDE);
      inp_base = INP_W'(int'(thread) * INP_STRIDE);
      wgt_base = WGT_W'(int'(thread) * WGT_STRIDE);
   end
endmodule

// File: rtl/vt_token_sync.sv
module vt_token_sync
   import vt_sync_pkg::*;
#(
   parameter int DEPTH      = 4,
   parameter int NUM_VT     = 2,
   parameter int ACC_STRIDE = 784,
   parameter int INP_STRIDE = 144,
   parameter int WGT_STRIDE = 72,
   parameter int ACC_W      = 11,
   parameter int INP_W      = 9,
   parameter int WGT_W      = 8,
   localparam int CW        = $clog2(DEPTH + 1),
   localparam int TW        = (NUM_VT > 1) ? $clog2(NUM_VT) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_valid,
   input  logic             ld_pop_c2l,
   input  logic             ld_push_l2c,
   output logic             ld_ready,
   input  logic             cmp_valid,
   input  logic             cmp_pop_l2c,
   input  logic             cmp_pop_c2l,
   input  logic             cmp_pop_s2c,
   input  logic             cmp_push_c2l,
   input  logic             cmp_push_c2s,
   input  logic [TW-1:0]    cmp_thread,
   output logic             cmp_ready,
   output logic [ACC_W-1:0] acc_base,
   output logic [INP_W-1:0] inp_base,
   output logic [WGT_W-1:0] wgt_base,
   input  logic             st_valid,
   input  logic             st_pop_c2s,
   input  logic             st_push_s2c,
   output logic             st_ready,
   input  logic             end_req,
   output logic [NQ-1:0]    ovf_err,
   output logic             sync_done
);
   if (DEPTH < 4)      begin : g_chk_depth $error("DEPTH must be at least 4"); end
   if (NUM_VT != 2)    begin : g_chk_vt    $error("exactly two virtual threads"); end
   if (NUM_VT > DEPTH) begin : g_chk_seed  $error("seed credits exceed DEPTH"); end
   if (ACC_STRIDE * (NUM_VT - 1) >= (1 << ACC_W)) begin : g_chk_acc
      $error("ACC_W too narrow");
   end

   logic [NSTG-1:0]         stg_valid, stg_issue;
   logic [NSTG-1:0][NQ-1:0] pop_mask, push_mask;
   logic [NQ-1:0][CW-1:0]   q_cnt;
   logic [NQ-1:0]           q_push;
   logic [NQ-1:0][PW-1:0]   q_pop;
   logic                    end_pend, pend_now, idle;

   always_comb begin
      stg_valid        = '0;
      stg_valid[S_LD]  = ld_valid;
      stg_valid[S_CMP] = cmp_valid;
      stg_valid[S_ST]  = st_valid;
      pop_mask  = '0;
      push_mask = '0;
      pop_mask[S_LD][Q_C2L]   = ld_pop_c2l;
      push_mask[S_LD][Q_L2C]  = ld_push_l2c;
      pop_mask[S_CMP][Q_L2C]  = cmp_pop_l2c;
      pop_mask[S_CMP][Q_C2L]  = cmp_pop_c2l;
      pop_mask[S_CMP][Q_S2C]  = cmp_pop_s2c;
      push_mask[S_CMP][Q_C2L] = cmp_push_c2l;
      push_mask[S_CMP][Q_C2S] = cmp_push_c2s;
      pop_mask[S_ST][Q_C2S]   = st_pop_c2s;
      push_mask[S_ST][Q_S2C]  = st_push_s2c;
   end

   vt_issue_arb #(.CW(CW)) u_arb (
      .valid     (stg_valid),
      .pop_mask  (pop_mask),
      .push_mask (push_mask),
      .cnt       (q_cnt),
      .issue     (stg_issue),
      .push      (q_push),
      .pop_n     (q_pop)
   );

   for (genvar q = 0; q < NQ; q++) begin : g_q
      vt_tok_cnt #(
         .DEPTH (DEPTH),
         .INIT  ((q == Q_S2C) ? NUM_VT : 0)
      ) u_cnt (
         .clk   (clk),
         .rst   (rst),
         .push  (q_push[q]),
         .pop_n (q_pop[q]),
         .cnt   (q_cnt[q]),
         .ovf   (ovf_err[q])
      );
   end

   vt_base #(
      .NUM_VT     (NUM_VT),
      .ACC_STRIDE (ACC_STRIDE),
      .INP_STRIDE (INP_STRIDE),
      .WGT_STRIDE (WGT_STRIDE),
      .ACC_W      (ACC_W),
      .INP_W      (INP_W),
      .WGT_W      (WGT_W)
   ) u_base (
      .thread   (cmp_thread),
      .acc_base (acc_base),
      .inp_base (inp_base),
      .wgt_base (wgt_base)
   );

   assign ld_ready  = stg_issue[S_LD];
   assign cmp_ready = stg_issue[S_CMP];
   assign st_ready  = stg_issue[S_ST];

   always_comb begin
      pend_now = end_pend | end_req;
      idle     = (q_cnt == '0) && (stg_valid == '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         end_pend  <= 1'b0;
         sync_done <= 1'b0;
      end else begin
         sync_done <= pend_now & idle;
         end_pend  <= pend_now & ~idle;
      end
   end
endmodule

// File: rtl/vt_token_sync_chk.sv
module vt_token_sync_chk
   import vt_sync_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input logic                  clk,
   input logic                  rst,
   input logic [NQ-1:0][CW-1:0] cnt,
   input logic [NQ-1:0]         push,
   input logic [NQ-1:0][PW-1:0] pop_n,
   input logic [NQ-1:0]         ovf,
   input logic [NSTG-1:0]       valid,
   input logic [NSTG-1:0]       issue,
   input logic                  sync_done
);
   for (genvar q = 0; q < NQ; q++) begin : g_q
      p_pop_covered_r2: assert property (@(posedge clk) disable iff (rst)
         (pop_n[q] != '0) |-> (int'(pop_n[q]) <= int'(cnt[q])));
      p_bound_r6: assert property (@(posedge clk) disable iff (rst)
         int'(cnt[q]) <= DEPTH);
      p_balanced_r6: assert property (@(posedge clk) disable iff (rst)
         (push[q] && pop_n[q] == PW'(1)) |=> $stable(cnt[q]));
      p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
         (push[q] && pop_n[q] == '0 && cnt[q] == CW'(DEPTH))
         |=> (ovf[q] && cnt[q] == CW'(DEPTH)));
   end

   for (genvar s = 0; s < NSTG; s++) begin : g_s
      p_issue_valid_r5: assert property (@(posedge clk) disable iff (rst)
         issue[s] |-> valid[s]);
   end

   p_sync_idle_r9: assert property (@(posedge clk) disable iff (rst)
      sync_done |-> (cnt == '0));
endmodule

bind vt_token_sync vt_token_sync_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cnt       (q_cnt),
   .push      (q_push),
   .pop_n     (q_pop),
   .ovf       (ovf_err),
   .valid     (stg_valid),
   .issue     (stg_issue),
   .sync_done (sync_done)
);

// File: tb/vt_token_sync_bench.sv
`timescale 1ns/1ps
module vt_token_sync_bench;
   localparam int DEPTH = 4;
   localparam int NVT   = 2;

   logic clk = 1'b0;
   logic rst;
   logic ld_valid, ld_pop_c2l, ld_push_l2c, ld_ready;
   logic cmp_valid, cmp_pop_l2c, cmp_pop_c2l, cmp_pop_s2c, cmp_push_c2l, cmp_push_c2s;
   logic [0:0] cmp_thread;
   logic cmp_ready;
   logic [10:0] acc_base;
   logic [8:0]  inp_base;
   logic [7:0]  wgt_base;
   logic st_valid, st_pop_c2s, st_push_s2c, st_ready;
   logic end_req;
   logic [3:0] ovf_err;
   logic sync_done;

   int nchk = 0, nfail = 0;
   int mcnt [4];
   logic mpend;
   int nsync = 0;

   always #2 clk = ~clk;   // 250 MHz

   vt_token_sync u_vt_token_sync (.*);

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // queue update: returns new count, sets drop flag
   function automatic int next_cnt(input int c, input int pu, input int po, output int drop);
      drop = (pu == 1 && po == 0 && c == DEPTH) ? 1 : 0;
      return (drop == 1) ? c : c + pu - po;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      {ld_valid, ld_pop_c2l, ld_push_l2c} = '0;
      {cmp_valid, cmp_pop_l2c, cmp_pop_c2l, cmp_pop_s2c, cmp_push_c2l, cmp_push_c2s} = '0;
      {st_valid, st_pop_c2s, st_push_s2c} = '0;
      cmp_thread = '0;
      end_req = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      mcnt = '{0, 0, 0, NVT};
      mpend = 1'b0;
      #1;
      chk("R1 ld_ready after reset", int'(ld_ready), 0);
      chk("R1 cmp_ready after reset", int'(cmp_ready), 0);
      chk("R1 st_ready after reset", int'(st_ready), 0);
      chk("R1 ovf_err after reset", int'(ovf_err), 0);
      chk("R1 sync_done after reset", int'(sync_done), 0);
   endtask

   // one cycle: l=load{v,pop,push} c=compute{v,popl2c,popc2l,pops2c,pushc2l,pushc2s} s=store{v,pop,push}
   task automatic step(input logic [2:0] l, input logic [5:0] c, input logic th,
                       input logic [2:0] s, input logic er);
      int claim [4];
      int pu [4];
      int li, ci, si, esync, ok, dr, eovf;
      @(negedge clk);
      {ld_valid, ld_pop_c2l, ld_push_l2c} = l;
      {cmp_valid, cmp_pop_l2c, cmp_pop_c2l, cmp_pop_s2c, cmp_push_c2l, cmp_push_c2s} = c;
      cmp_thread = th;
      {st_valid, st_pop_c2s, st_push_s2c} = s;
      end_req = er;
      claim = '{0, 0, 0, 0};
      // compute first (R3 precedence), then load, then store
      ok = c[5];
      if (c[4] && mcnt[0] <= claim[0]) ok = 0;
      if (c[3] && mcnt[1] <= claim[1]) ok = 0;
      if (c[2] && mcnt[3] <= claim[3]) ok = 0;
      ci = ok;
      if (ci == 1) begin
         claim[0] += int'(c[4]); claim[1] += int'(c[3]); claim[3] += int'(c[2]);
      end
      ok = l[2];
      if (l[1] && mcnt[1] <= claim[1]) ok = 0;
      li = ok;
      if (li == 1) claim[1] += int'(l[1]);
      ok = s[2];
      if (s[1] && mcnt[2] <= claim[2]) ok = 0;
      si = ok;
      if (si == 1) claim[2] += int'(s[1]);
      pu[0] = li & int'(l[0]);
      pu[1] = ci & int'(c[1]);
      pu[2] = ci & int'(c[0]);
      pu[3] = si & int'(s[0]);
      esync = ((mpend | er) && mcnt[0] == 0 && mcnt[1] == 0 && mcnt[2] == 0 &&
               mcnt[3] == 0 && !l[2] && !c[5] && !s[2]) ? 1 : 0;
      #1;
      chk("R2 ld_ready", int'(ld_ready), li);
      chk("R3 cmp_ready", int'(cmp_ready), ci);
      chk("R4 st_ready", int'(st_ready), si);
      chk("R8 acc_base", int'(acc_base), int'(th) * 784);
      chk("R8 inp_base", int'(inp_base), int'(th) * 144);
      chk("R8 wgt_base", int'(wgt_base), int'(th) * 72);
      eovf = 0;
      for (int q = 0; q < 4; q++) begin
         mcnt[q] = next_cnt(mcnt[q], pu[q], claim[q], dr);
         if (dr == 1) eovf |= (1 << q);
      end
      mpend = (mpend | er) & (esync == 0);
      @(posedge clk);
      #1;
      chk("R7 ovf_err", int'(ovf_err), eovf);
      chk("R9 sync_done", int'(sync_done), esync);
      if (sync_done) nsync++;
   endtask

   localparam logic [2:0] LNONE = 3'b000;
   localparam logic [5:0] CNONE = 6'b000000;
   localparam logic [2:0] SNONE = 3'b000;

   initial begin : wdog
      #(4ns * 150000);
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      do_reset();

      // R1: two seeded credits, a third pop stalls (R5 held)
      step(LNONE, 6'b100100, 1'b0, SNONE, 1'b0);
      step(LNONE, 6'b100100, 1'b1, SNONE, 1'b0);
      step(LNONE, 6'b100100, 1'b0, SNONE, 1'b0);
      // R4: store stalls on empty compute-to-store, then issues once token arrives
      step(LNONE, CNONE, 1'b0, 3'b111, 1'b0);
      step(LNONE, 6'b100001, 1'b0, 3'b111, 1'b0);
      step(LNONE, CNONE, 1'b0, 3'b111, 1'b0);

      // R7 / R6: overflow compute-to-store, then balanced push+pop while full
      do_reset();
      for (int i = 0; i < DEPTH + 2; i++) step(LNONE, 6'b100001, 1'b1, SNONE, 1'b0);
      step(LNONE, 6'b100001, 1'b0, 3'b110, 1'b0);
      step(LNONE, 6'b100001, 1'b0, SNONE, 1'b0);
      for (int i = 0; i < DEPTH + 1; i++) step(LNONE, CNONE, 1'b0, 3'b110, 1'b0);

      // R3: compute wins the last compute-to-load token over load
      do_reset();
      step(LNONE, 6'b100110, 1'b0, SNONE, 1'b0);
      step(3'b110, 6'b101000, 1'b0, SNONE, 1'b0);
      step(3'b110, CNONE, 1'b0, SNONE, 1'b0);

      // replay of a two-thread tile with two reduction steps, then drain and sync
      do_reset();
      for (int t = 0; t < NVT; t++) step(LNONE, 6'b100110, 1'(t), SNONE, 1'b0);
      step(LNONE, 6'b110010, 1'b0, SNONE, 1'b0);        // early gemm must stall
      for (int k = 0; k < 2; k++) begin
         for (int t = 0; t < NVT; t++) step(3'b111, CNONE, 1'b0, SNONE, 1'b0);
         for (int t = 0; t < NVT; t++) step(LNONE, 6'b110010, 1'(t), SNONE, 1'b0);
      end
      for (int t = 0; t < NVT; t++) step(LNONE, 6'b101000, 1'(t), SNONE, 1'b0);
      for (int t = 0; t < NVT; t++) step(LNONE, 6'b100001, 1'(t), SNONE, 1'b0);
      for (int t = 0; t < NVT; t++) step(LNONE, CNONE, 1'b0, 3'b111, 1'b0);
      step(LNONE, CNONE, 1'b0, SNONE, 1'b1);            // end: not yet idle
      for (int t = 0; t < NVT; t++) step(LNONE, 6'b100100, 1'(t), SNONE, 1'b0);
      step(LNONE, CNONE, 1'b0, SNONE, 1'b0);
      step(LNONE, CNONE, 1'b0, SNONE, 1'b0);
      chk("R9 single sync pulse at end of replay", nsync, 1);

      // random mix
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         step({r[0], r[1], r[2]},
              {r[3] | r[4], r[5], r[6] & r[7], r[8], r[9], r[10]},
              r[11],
              {r[12], r[13], r[14]},
              (r[20:16] == 5'd0));
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule